// File: doc/BRIEF.md
# Burst-Addressed Synchronous Cache Data Memory

This block is a synchronous static memory for a cache data path. Every input except the output enable is captured on the rising clock edge. A line access starts with one of two address strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, chosen by the byte write enables. Once a base address is loaded, an internal two-bit beat counter produces the rest of the cache line in interleaved order. An advance input steps the counter, and holding that input high inserts a wait beat.

The default array holds 1024 words of 18 bits, stored as two 9-bit byte lanes. Each lane has its own write enable. Read data is held in an output register. It is driven only while the device is selected, the last access was a read and the asynchronous output enable is low. At every other time the output enable flag is low and the data lines are released (modelled as zero). A processor-strobe write takes two cycles: the address is presented with the strobe, and the data follows with both strobes negated.

Top module: `burst_sram`

## Requirements
- R1: A cycle with `pstrobe_n`=0 and `ce_n`=0 loads the external address as the new base and is always a read, whatever the values of `byte_we_n` and `cstrobe_n`; the memory is not written.
- R2: A cycle with `cstrobe_n`=0 that R1 does not cover loads the external address as the new base. It writes when any bit of `byte_we_n` is 0 and reads otherwise.
- R3: `ce_n` is sampled only in a cycle that loads a base address. A cycle with `pstrobe_n`=0, `ce_n`=1 and `cstrobe_n`=1 loads nothing and continues the current burst. After a load with `ce_n`=1, the following continuation beats neither read nor write.
- R4: A processor-strobe write takes two cycles. Cycle 1 presents the address with `pstrobe_n`=0 and `ce_n`=0. Cycle 2 has both strobes high, `adv_n`=1 and a byte enable low, and it writes the data to the address from cycle 1. `addr` and `ce_n` are ignored in cycle 2.
- R5: In a beat with both strobes high, `adv_n`=0 steps the beat count by one before the access. `adv_n`=1 keeps the count, so the same word is accessed again.
- R6: The two low bits of the access address equal the base's two low bits XOR the beat count (0..3, modulo 4). The upper bits come from the base. After the fourth beat the sequence wraps back to the base word.
- R7: `byte_we_n[0]`=0 writes `wdata[8:0]` and `byte_we_n[1]`=0 writes `wdata[17:9]`. A lane whose enable is 1 keeps its stored bits.
- R8: `rdata_en` is 0 after any write cycle and after any deselected cycle. It drops at once, with no clock edge, while `oe_n`=1.
- R9: Read data for an address sampled at a clock edge is on `rdata` right after that edge, with `rdata_en`=1 while `oe_n`=0. Before that edge, the previous output is unchanged.
- R10: During and after reset the device is deselected and `rdata_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 10 | External word address |
| wdata | input | 18 | Write data |
| ce_n | input | 1 | Chip enable, active low, sampled on base loads |
| pstrobe_n | input | 1 | Processor address strobe, active low |
| cstrobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_we_n | input | 2 | Byte-lane write enables, active low; bit 0 lower lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data, zero when not driven |
| rdata_en | output | 1 | Output driver enable of the data lines |

## Verification
The hardest case to reach is a processor strobe that arrives with the chip enable high in the middle of a burst. From the ports it looks like a new burst, yet it must be ignored, and the only evidence is which word the burst reaches next. The stimulus first runs a burst partway through its wrap sequence. It then issues the ignored strobe with a different address while holding the advance input high, and the next advance must still return the interleaved neighbour of the old base. A similar case is the deselected burst: write enables are pulsed during its continuation beats, and the untouched words are read back afterwards.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // interleaved line order: low address bits of the base XOR the beat count
  function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] base_lo,
                                                     input logic [BEAT_W-1:0] beat);
    return base_lo ^ beat;
  endfunction

  function automatic logic [BEAT_W-1:0] beat_step(input logic [BEAT_W-1:0] beat,
                                                   input logic             hold);
    return hold ? beat : beat + 1'b1;
  endfunction

endpackage

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              adv_n,
  input  logic              any_we,
  output logic [ADDR_W-1:0] acc_addr,
  output sram_op_e          op
);

  logic [ADDR_W-1:0] base_q, base_use;
  logic [BEAT_W-1:0] beat_q, beat_nxt;
  logic              sel_q, sel_use;
  logic              load_p, load_c, load_any;

  // processor strobe wins; with chip enable high it falls through
  assign load_p   = !pstb_n && !ce_n;
  assign load_c   = !cstb_n && !load_p;
  assign load_any = load_p || load_c;

  assign base_use = load_any ? addr : base_q;
  assign beat_nxt = load_any ? '0 : beat_step(beat_q, adv_n);
  assign sel_use  = load_any ? !ce_n : sel_q;

  assign acc_addr = {base_use[ADDR_W-1:BEAT_W], beat_offset(base_use[BEAT_W-1:0], beat_nxt)};

  always_comb begin
    if (!sel_use)    op = OP_IDLE;
    else if (load_p) op = OP_READ;
    else if (any_we) op = OP_WRITE;
    else             op = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_use;
      beat_q <= beat_nxt;
      sel_q  <= sel_use;
    end
  end

  p_ignore_pstrobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && ce_n && cstb_n) |=> $stable(base_q));

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pstb_n && cstb_n && adv_n) |=> $stable(beat_q));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstb_n && cstb_n && !adv_n && beat_q == 2'd3) |=> (beat_q == 2'd0));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic [LANES-1:0]        lane_we,
  output logic [LANE_W*LANES-1:0] rdata_q
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr && lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd)               q         <= mem[addr];
    end

    assign rdata_q[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              wr_fire,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              drive,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= rd_fire;
  end

  assign drive = valid_q && !oe_n;
  assign dout  = drive ? data_q : '0;

  p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !drive);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic                    ce_n,
  input  logic                    pstrobe_n,
  input  logic                    cstrobe_n,
  input  logic                    adv_n,
  input  logic [LANES-1:0]        byte_we_n,
  input  logic                    oe_n,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic                    rdata_en
);

  localparam int DATA_W = LANE_W * LANES;

  logic [ADDR_W-1:0] acc_addr;
  sram_op_e          op;
  logic              rd_fire, wr_fire, rd_pipe_valid;
  logic [DATA_W-1:0] array_q;

  burst_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ce_n     (ce_n),
    .pstb_n   (pstrobe_n),
    .cstb_n   (cstrobe_n),
    .adv_n    (adv_n),
    .any_we   (~&byte_we_n),
    .acc_addr (acc_addr),
    .op       (op)
  );

  assign rd_fire = (op == OP_READ);
  assign wr_fire = (op == OP_WRITE);

  sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk     (clk),
    .wr      (wr_fire),
    .rd      (rd_fire),
    .addr    (acc_addr),
    .wdata   (wdata),
    .lane_we (~byte_we_n),
    .rdata_q (array_q)
  );

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .oe_n    (oe_n),
    .data_q  (array_q),
    .valid_q (rd_pipe_valid),
    .drive   (rdata_en),
    .dout    (rdata)
  );

  p_pload_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstrobe_n && !ce_n) |=> rd_pipe_valid);

  p_cload_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstrobe_n && pstrobe_n && !ce_n && !(&byte_we_n)) |=> !rd_pipe_valid);

  p_desel_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstrobe_n && pstrobe_n && ce_n) |=> !rdata_en);

  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> !rd_pipe_valid);

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  addr;
  logic [17:0] wdata;
  logic        ce_n, pstrobe_n, cstrobe_n, adv_n, oe_n;
  logic [1:0]  byte_we_n;
  logic [17:0] rdata;
  logic        rdata_en;

  logic [17:0] refm [1024];
  int nvec = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
    .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n), .adv_n(adv_n),
    .byte_we_n(byte_we_n), .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en)
  );

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: apply at the falling edge, sample at the next falling edge
  task automatic cyc(input logic ps, input logic cs, input logic ce, input logic adv,
                     input logic [1:0] we, input logic [9:0] a, input logic [17:0] d);
    pstrobe_n = ps; cstrobe_n = cs; ce_n = ce; adv_n = adv;
    byte_we_n = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cwrite(input logic [9:0] a, input logic [17:0] d);
    cyc(1, 0, 0, 1, 2'b00, a, d);
    refm[a] = d;
  endtask

  task automatic cread(input string req, input logic [9:0] a);
    cyc(1, 0, 0, 1, 2'b11, a, '0);
    chk(req, {17'd0, rdata_en}, 18'd1);
    chk(req, rdata, refm[a]);
  endtask

  task automatic t_reset;
    chk("R10 reset", {17'd0, rdata_en}, 18'd0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) begin
      cwrite(10'(i), 18'h2A000 ^ 18'(i * 18'h0131));
      if (i == 0) chk("R8 write hiz", {17'd0, rdata_en}, 18'd0);
    end
    cread("R2 ctl read", 10'd3);
  endtask

  task automatic t_burst_wrap;
    logic [9:0] seq [4];
    seq[0] = 10'd11; seq[1] = 10'd8; seq[2] = 10'd9; seq[3] = 10'd10;
    cyc(0, 1, 0, 1, 2'b11, 10'd10, '0);
    chk("R6 beat0", rdata, refm[10]);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 1, 0, 2'b11, 10'd0, '0);
      chk(k == 3 ? "R6 wrap" : "R5 advance", rdata, refm[seq[k]]);
    end
  endtask

  task automatic t_wait_and_ignore;
    cyc(0, 1, 0, 1, 2'b11, 10'd13, '0);
    chk("R1 pload read", rdata, refm[13]);
    cyc(1, 1, 0, 1, 2'b11, 10'd0, '0);
    chk("R5 wait beat", rdata, refm[13]);
    cyc(1, 1, 0, 0, 2'b11, 10'd0, '0);
    chk("R5 step", rdata, refm[12]);
    cyc(1, 1, 0, 0, 2'b11, 10'd0, '0);
    chk("R6 interleave", rdata, refm[15]);
    // processor strobe with chip enable high: must not reload the base
    cyc(0, 1, 1, 1, 2'b11, 10'd3, '0);
    chk("R3 ignored strobe", rdata, refm[15]);
    cyc(1, 1, 1, 0, 2'b11, 10'd3, '0);
    chk("R3 base kept", rdata, refm[14]);
  endtask

  task automatic t_pload_no_write;
    cyc(0, 0, 0, 1, 2'b00, 10'd5, 18'h15555);
    chk("R1 read despite we", rdata, refm[5]);
    cread("R1 memory untouched", 10'd5);
  endtask

  task automatic t_two_cycle_write;
    cyc(0, 1, 0, 1, 2'b11, 10'd6, '0);
    cyc(1, 1, 1, 1, 2'b00, 10'd0, 18'h0BEEF);
    refm[6] = 18'h0BEEF;
    chk("R8 hiz after write", {17'd0, rdata_en}, 18'd0);
    cread("R4 two-cycle write", 10'd6);
    cread("R4 addr in cycle2 ignored", 10'd0);
  endtask

  task automatic t_lanes;
    cyc(1, 0, 0, 1, 2'b10, 10'd7, 18'h3FFFF);
    refm[7][8:0] = 9'h1FF;
    cyc(1, 0, 0, 1, 2'b01, 10'd4, 18'h3FFFF);
    refm[4][17:9] = 9'h1FF;
    cread("R7 lower lane", 10'd7);
    cread("R7 upper lane", 10'd4);
  endtask

  task automatic t_deselect;
    cyc(1, 0, 1, 1, 2'b11, 10'd2, '0);
    chk("R8 deselected", {17'd0, rdata_en}, 18'd0);
    cyc(1, 1, 0, 0, 2'b00, 10'd9, 18'h12345);
    chk("R3 desel write beat", {17'd0, rdata_en}, 18'd0);
    cyc(1, 1, 0, 0, 2'b11, 10'd9, '0);
    chk("R3 desel read beat", {17'd0, rdata_en}, 18'd0);
    cread("R3 desel no write", 10'd3);
    cread("R3 desel no write", 10'd9);
  endtask

  task automatic t_oe_and_latency;
    cread("R9 read", 10'd1);
    oe_n = 1'b1;
    #1;
    chk("R8 async oe off", {17'd0, rdata_en}, 18'd0);
    oe_n = 1'b0;
    #1;
    chk("R8 async oe on", rdata, refm[1]);
    pstrobe_n = 1; cstrobe_n = 0; ce_n = 0; adv_n = 1; byte_we_n = 2'b11; addr = 10'd14;
    #1;
    chk("R9 before edge", rdata, refm[1]);
    @(posedge clk);
    @(negedge clk);
    chk("R9 after edge", rdata, refm[14]);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nerr++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; ce_n = 1'b1; pstrobe_n = 1'b1;
    cstrobe_n = 1'b1; adv_n = 1'b1; byte_we_n = 2'b11; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_burst_wrap();
    t_wait_and_ignore();
    t_pload_no_write();
    t_two_cycle_write();
    t_lanes();
    t_deselect();
    t_oe_and_latency();
    report();
    $finish;
  end

endmodule